// File: doc/BRIEF.md
# Daisy-Chain Serial Command Receiver

This block is the slave end of a three-wire serial link: chip select (active low), serial clock and serial data. While chip select is low it takes one bit from the data line on every falling edge of the serial clock, most significant bit first. Once 24 bits have arrived it presents them as a parallel word with a single-cycle valid strobe. The word is an 8-bit control byte followed by 16 data bits. Any bits after the 24th in the same frame are ignored. If chip select rises before the 24th bit, the frame is dropped without a trace.

After the 24th bit the block pulls its active-low ready output low and holds it there until chip select rises. Wired to the chip select of the next device, ready lets a chain of devices share the serial clock and data lines: each device consumes the first 24 bits it sees and then opens the line to the next one. Ready can be switched off by a power-control word, meaning control byte 0x03 with the enable in word bit 7. When it is off, ready stays high.

All three serial inputs are asynchronous. They pass through two-flop synchronisers into the system clock domain, and serial clock edges are found from the synchronised samples.

Top module: `daisy_cmd_rx`

## Requirements
- R1: While chip select is low, each synchronised falling edge of the serial clock shifts one data bit in. The first bit of a frame becomes word bit 23 and the 24th becomes bit 0.
- R2: On the 24th falling edge of a frame, `cmdValid` is high for exactly one system clock cycle, no later than three clock edges after the edge reaches the pins. `cmdWord` carries the received word in that same cycle.
- R3: If chip select rises after fewer than 24 falling edges, no strobe is produced, `cmdWord` keeps its previous value, and ready stays high.
- R4: Falling edges after the 24th in the same frame produce no second strobe and leave `cmdWord` unchanged.
- R5: While ready is enabled, `readyN` goes low in the same cycle as the strobe and stays low while chip select remains low.
- R6: `readyN` returns high within four system clock cycles of chip select rising.
- R7: A completed word whose bits 23:16 equal 0x03 loads the ready enable from its bit 7, where 1 means enabled. The new value already governs `readyN` for the frame that carried it. While the enable is 0, `readyN` stays high.
- R8: Serial clock falling edges while chip select is high have no effect. The clock may idle either high or low between frames.
- R9: After reset, `readyN` is high, `cmdValid` is low, `cmdWord` is zero and ready is enabled. `cmdWord` changes only in a cycle where `cmdValid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to sample the serial lines |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select that frames a transfer |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| din | input | 1 | Serial data, MSB first |
| readyN | output | 1 | Active-low ready; drives the next device's chip select |
| cmdWord | output | 24 | Last complete received word |
| cmdValid | output | 1 | One-cycle strobe for a new word |

## Verification
The bench builds the block with its default 24-bit word, 8-bit control field and two synchroniser stages. At these values every frame length from 0 to 30 bits can be swept, covering short, exact and over-long frames, with the serial clock idling both high and low. Power-control words are placed in the sweep so that ready is switched off and back on. A walking-one pass checks that every one of the 24 bit positions lands in the right place.

// File: rtl/daisy_cmd_rx_pkg.sv
package daisy_cmd_rx_pkg;
  // strobes from frame control to the word datapath
  typedef struct packed {
    logic shiftBit;  // take the current data bit
    logic commit;    // this bit completes the word
  } rx_strobe_t;
endpackage

// File: rtl/daisy_cmd_rx_sync.sv
module daisy_cmd_rx_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= RESET_VAL;
        else       stage[s] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= RESET_VAL;
        else       stage[s] <= stage[s-1];
      end
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/daisy_cmd_rx_ctrl.sv
module daisy_cmd_rx_ctrl
  import daisy_cmd_rx_pkg::*;
#(
  parameter int WORD_BITS = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csLvl,
  input  logic       sclkLvl,
  input  logic       readyEn,
  output rx_strobe_t strobe,
  output logic       readyN
);
  localparam int CNT_W = $clog2(WORD_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_BITS - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_BITS);

  logic [CNT_W-1:0] bitCount;
  logic sclkPrev;
  logic frameDone;
  logic sclkFall;

  assign sclkFall = sclkPrev & ~sclkLvl;

  always_comb begin
    strobe.shiftBit = ~csLvl & sclkFall & (bitCount < FULL_CNT);
    strobe.commit   = strobe.shiftBit & (bitCount == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev  <= 1'b0;
      bitCount  <= '0;
      frameDone <= 1'b0;
    end else begin
      sclkPrev <= sclkLvl;
      if (csLvl) begin
        bitCount  <= '0;
        frameDone <= 1'b0;
      end else if (strobe.shiftBit) begin
        bitCount <= bitCount + 1'b1;
        if (strobe.commit) frameDone <= 1'b1;
      end
    end
  end

  assign readyN = ~(frameDone & readyEn);
endmodule

// File: rtl/daisy_cmd_rx_dp.sv
module daisy_cmd_rx_dp
  import daisy_cmd_rx_pkg::*;
#(
  parameter int WORD_BITS = 24,
  parameter int CTRL_BITS = 8,
  parameter logic [CTRL_BITS-1:0] PWR_CODE = 8'h03,
  parameter int READY_EN_BIT = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 dinBit,
  input  rx_strobe_t           strobe,
  output logic [WORD_BITS-1:0] wordOut,
  output logic                 wordValid,
  output logic                 readyEn
);
  logic [WORD_BITS-1:0] shiftReg;
  logic [WORD_BITS-1:0] nextWord;
  logic isPwrCmd;

  assign nextWord = {shiftReg[WORD_BITS-2:0], dinBit};
  assign isPwrCmd = (nextWord[WORD_BITS-1 -: CTRL_BITS] == PWR_CODE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      wordOut   <= '0;
      wordValid <= 1'b0;
      readyEn   <= 1'b1;
    end else begin
      wordValid <= strobe.commit;
      if (strobe.shiftBit) shiftReg <= nextWord;
      if (strobe.commit) begin
        wordOut <= nextWord;
        if (isPwrCmd) readyEn <= nextWord[READY_EN_BIT];
      end
    end
  end
endmodule

// File: rtl/daisy_cmd_rx.sv
module daisy_cmd_rx
  import daisy_cmd_rx_pkg::*;
#(
  parameter int WORD_BITS = 24,
  parameter int CTRL_BITS = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [CTRL_BITS-1:0] PWR_CODE = 8'h03,
  parameter int READY_EN_BIT = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 sclk,
  input  logic                 din,
  output logic                 readyN,
  output logic [WORD_BITS-1:0] cmdWord,
  output logic                 cmdValid
);
  logic [2:0] syncBus;
  rx_strobe_t strobe;
  logic readyEn;

  daisy_cmd_rx_sync #(
    .WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)
  ) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn({csN, sclk, din}), .syncOut(syncBus)
  );

  daisy_cmd_rx_ctrl #(.WORD_BITS(WORD_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .csLvl(syncBus[2]), .sclkLvl(syncBus[1]),
    .readyEn(readyEn), .strobe(strobe), .readyN(readyN)
  );

  daisy_cmd_rx_dp #(
    .WORD_BITS(WORD_BITS), .CTRL_BITS(CTRL_BITS),
    .PWR_CODE(PWR_CODE), .READY_EN_BIT(READY_EN_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .dinBit(syncBus[0]), .strobe(strobe),
    .wordOut(cmdWord), .wordValid(cmdValid), .readyEn(readyEn)
  );
endmodule

// File: rtl/daisy_cmd_rx_chk.sv
module daisy_cmd_rx_chk #(
  parameter int WORD_BITS = 24
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 csN,
  input logic                 readyN,
  input logic                 cmdValid,
  input logic [WORD_BITS-1:0] cmdWord
);
  logic [1:0] sinceRst;
  logic histOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 1'b1;
  end
  assign histOk = (sinceRst == 2'd3);

  // R2
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  // R9
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> $stable(cmdWord));

  // R5
  ready_with_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readyN) |-> cmdValid);

  // R6
  ready_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (histOk && csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> readyN);

  // R8
  no_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (histOk && cmdValid) |-> !$past(csN, 3));
endmodule

bind daisy_cmd_rx daisy_cmd_rx_chk #(.WORD_BITS(WORD_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .readyN(readyN),
  .cmdValid(cmdValid), .cmdWord(cmdWord)
);

// File: tb/tb_daisy_cmd_rx.sv
module tb_daisy_cmd_rx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic din = 1'b0;
  logic readyN;
  logic cmdValid;
  logic [23:0] cmdWord;

  int checks = 0;
  int failures = 0;
  int validCount = 0;
  logic readyEnExp = 1'b1;
  logic [23:0] wordExp = '0;

  always #5 clk = ~clk;

  daisy_cmd_rx dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .readyN(readyN), .cmdWord(cmdWord), .cmdValid(cmdValid)
  );

  always @(negedge clk) if (rstN && cmdValid) validCount++;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [23:0] w, input logic [5:0] extra,
                            input int len, input bit idleHigh, input bit preToggle);
    logic [29:0] stream;
    bit pwr;
    stream = {w, extra};
    sclk = idleHigh;
    csN = 1'b1;
    tick(4);
    if (preToggle) begin
      validCount = 0;
      for (int k = 0; k < 5; k++) begin
        din = k[0]; sclk = ~sclk; tick(4); sclk = ~sclk; tick(4);
      end
      check("R8", "strobes with chip select high", validCount, 0);
      check("R8", "word after idle clocks", cmdWord, wordExp);
    end
    validCount = 0;
    csN = 1'b0;
    tick(4);
    for (int k = 0; k < len; k++) begin
      din = stream[29-k];
      if (idleHigh) begin
        tick(4); sclk = 1'b0; tick(4); sclk = 1'b1;
      end else begin
        sclk = 1'b1; tick(4); sclk = 1'b0; tick(4);
      end
    end
    tick(4);
    pwr = (len >= 24) && (w[23:16] == 8'h03);
    if (len >= 24) begin
      wordExp = w;
      if (pwr) readyEnExp = w[7];
    end
    if (len >= 24)
      check((pwr || !readyEnExp) ? "R7" : "R5", "readyN in frame", readyN, !readyEnExp);
    else
      check("R3", "readyN in short frame", readyN, 1);
    csN = 1'b1;
    tick(5);
    check("R6", "readyN after chip select rise", readyN, 1);
    check(len > 24 ? "R4" : (len == 24 ? "R2" : "R3"), "strobe count", validCount,
          (len >= 24) ? 1 : 0);
    check(len >= 24 ? "R1" : "R3", "cmdWord", cmdWord, wordExp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(2);
    check("R9", "reset readyN", readyN, 1);
    check("R9", "reset cmdValid", cmdValid, 0);
    check("R9", "reset cmdWord", cmdWord, 0);

    for (int idle = 0; idle < 2; idle++) begin
      for (int len = 0; len <= 30; len++) begin
        logic [31:0] mix;
        logic [23:0] w;
        mix = (32'(len + 31 * idle) + 32'd1) * 32'h9E3779B1;
        w = mix[28:5];
        if (w[23:16] == 8'h03) w[23:16] = 8'h13;
        if (len % 4 == 0) begin
          w[23:16] = 8'h03;
          w[7] = (len % 8 != 0);
        end
        send_frame(w, mix[5:0], len, idle[0], len[0]);
      end
    end

    for (int p = 0; p < 24; p++) begin
      send_frame(24'(1) << p, 6'h2A, 24, p[0], 1'b0);
    end

    send_frame(24'h030080, 6'h3F, 30, 1'b0, 1'b0);
    send_frame(24'hA5C3F0, 6'h00, 24, 1'b1, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule